// File: doc/BRIEF.md
# Serial EEPROM Target with Write Protect

This block is a two-wire serial target that fronts a byte-wide storage array and acts like a serial EEPROM. The system clock samples the SCL and SDA lines through a short glitch filter. The block detects START and STOP conditions and matches the device-select byte. It then accepts a word address and data bytes, or it returns stored bytes. SDA is open-drain: the block only ever asserts `sda_oe`, which pulls the line low.

Writes are staged one page at a time. They are committed after the STOP, at the end of a self-timed write cycle whose length in clock cycles is a parameter. While that cycle runs, the block refuses its own device address, so a host can poll for completion.

A write-protect input is watched across a window. The window opens when the block captures the last bit of the first data byte and closes when the write cycle ends. Protect seen high anywhere in that window leaves the array untouched. During the write cycle it also ends the cycle at once.

Top module: `i2c_eeprom_target`

## Requirements
- R1: The block samples SDA on a rising SCL edge and changes its drive of SDA only while SCL is low. A high-to-low SDA transition with SCL high is a START. A low-to-high SDA transition with SCL high is a STOP.
- R2: A device-select byte is acknowledged only when all of the following hold:
  - bits 7..4 equal `DEV_ID` (default 1010);
  - bits 3..1 equal `sel_i`;
  - no write cycle is running.

  Bit 0 selects the direction: 1 is read, 0 is write. On a mismatch the block releases SDA and ignores the bus until the next START.
- R3: After reset, SDA is released and every array location reads FFh.
- R4: A byte write is one word-address byte, when `ADDR_W` ≤ 8, followed by one data byte and a STOP. The byte is stored once the write cycle completes.
- R5: In a page write, successive data bytes go to successive addresses, but only the low page bits advance. The page is 8 bytes for 7–8 address bits, 16 bytes for 9–11, and 32 bytes above that. Bytes past the page end wrap to the page start.
- R6: A random read is a write-direction select and a word address, then a repeated START and a read-direction select. A current-address read is a read-direction select with no address. The current address advances by one after every byte sent.
- R7: A sequential read continues while the host acknowledges each byte. The full address increments and wraps from the top location to 0. After a host NACK the block releases SDA.
- R8: From the STOP that starts a write cycle until `WR_CYC` clock cycles later, the device address is not acknowledged. Afterwards it is acknowledged again.
- R9: `wp_i` high at the capture of the first data byte's last bit, or at any point until the STOP, cancels the write. The array is unchanged and no write cycle starts.
- R10: `wp_i` high during a write cycle ends the cycle in the next clock. Nothing is committed.
- R11: A pulse on SCL or SDA shorter than `FILT_CYC` clock cycles has no effect on the transfer.
- R12: A repeated START after write data discards that data. Nothing is committed and no write cycle starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sel_i | input | 3 | Strap value that must match bits 3..1 of the device-select byte |
| wp_i | input | 1 | Write protect, active high |
| sda_oe | output | 1 | When 1, pull SDA low; when 0, release the line |

## Verification
Assertions check the following on every cycle:
- the block never starts pulling SDA while the filtered SCL is high;
- SDA stays released whenever the block is not addressed;
- no acknowledge drive appears while a write cycle runs;
- a write cycle never starts after protect was seen in the window;
- protect high during a write cycle ends it on the next clock.

Only the bench's scenarios show:
- that the stored contents are right after byte and page writes, including the in-page wrap;
- that the read address advances correctly across current, random and sequential reads, including the top-to-zero wrap;
- that a cancelled or aborted write left the array untouched;
- that filtered glitches and repeated STARTs do not disturb the data.

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int         ADDR_W   = 8,
  parameter logic [3:0] DEV_ID   = 4'b1010,
  parameter int         FILT_CYC = 3,
  parameter int         WR_CYC   = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] sel_i,
  input  logic       wp_i,
  output logic       sda_oe
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PW     = (ADDR_W <= 8) ? 3 : (ADDR_W <= 11) ? 4 : 5;
  localparam int PAGE   = 1 << PW;
  localparam int PBW    = ADDR_W - PW;
  localparam int ABYTES = (ADDR_W > 8) ? 2 : 1;
  localparam int FW     = $clog2(FILT_CYC + 1);
  localparam int CW     = $clog2(WR_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WA, S_WD, S_RD} st_t;

  // glitch filter: a level change must persist FILT_CYC cycles
  logic [1:0] raw, filt;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_flt
    logic [1:0]    sync;
    logic [FW-1:0] cnt;
    logic          lvl;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync <= 2'b11;
        cnt  <= '0;
        lvl  <= 1'b1;
      end else begin
        sync <= {sync[0], raw[g]};
        if (sync[1] == lvl) cnt <= '0;
        else if (cnt == FW'(FILT_CYC - 1)) begin
          lvl <= sync[1];
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
      end
    end
    assign filt[g] = lvl;
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = filt[1];
  assign sda_f = filt[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire start_c  = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_c   = scl_f & scl_q & ~sda_q & sda_f;

  st_t              st, nxt;
  logic [3:0]       bitcnt;
  logic [6:0]       sr;
  logic             ack_pend, abyte, wp_kill, busy;
  logic [ADDR_W-1:0] ptr;
  logic [PBW-1:0]   pg_base;
  logic [7:0]       wa_hi;
  logic [CW-1:0]    wcnt;
  logic [PAGE-1:0]  pvalid;
  logic [7:0]       pbuf [PAGE];
  logic [7:0]       mem  [DEPTH];

  wire [7:0]  rx_b    = {sr, sda_f};
  wire [15:0] wa_full = {wa_hi, rx_b};
  wire [7:0]  rd_byte = mem[ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      nxt      <= S_IDLE;
      bitcnt   <= '0;
      sr       <= '0;
      ack_pend <= 1'b0;
      abyte    <= 1'b0;
      wp_kill  <= 1'b0;
      busy     <= 1'b0;
      ptr      <= '0;
      pg_base  <= '0;
      wa_hi    <= '0;
      wcnt     <= '0;
      pvalid   <= '0;
      sda_oe   <= 1'b0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= 8'h00;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (st == S_WD && pvalid != '0 && wp_i) wp_kill <= 1'b1;

      if (busy) begin
        if (wp_i) busy <= 1'b0;
        else if (wcnt == CW'(WR_CYC - 1)) begin
          busy <= 1'b0;
          for (int i = 0; i < PAGE; i++)
            if (pvalid[i]) mem[{pg_base, PW'(i)}] <= pbuf[i];
        end else wcnt <= wcnt + 1'b1;
      end

      if (start_c) begin
        st     <= S_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        if (st == S_WD && pvalid != '0 && !wp_kill && !wp_i) begin
          busy <= 1'b1;
          wcnt <= '0;
        end
      end else if (scl_rise && st != S_IDLE) begin
        if (bitcnt < 4'd8) begin
          sr     <= {sr[5:0], sda_f};
          bitcnt <= bitcnt + 1'b1;
        end
        if (bitcnt == 4'd7) begin
          case (st)
            S_DEV: begin
              if (rx_b[7:4] == DEV_ID && rx_b[3:1] == sel_i && !busy) begin
                ack_pend <= 1'b1;
                nxt      <= rx_b[0] ? S_RD : S_WA;
                abyte    <= 1'b0;
              end else begin
                ack_pend <= 1'b0;
                nxt      <= S_IDLE;
              end
            end
            S_WA: begin
              ack_pend <= 1'b1;
              if (ABYTES == 2 && !abyte) begin
                wa_hi <= rx_b;
                abyte <= 1'b1;
                nxt   <= S_WA;
              end else begin
                ptr     <= ADDR_W'(wa_full);
                pg_base <= PBW'(wa_full >> PW);
                pvalid  <= '0;
                wp_kill <= 1'b0;
                nxt     <= S_WD;
              end
            end
            S_WD: begin
              ack_pend              <= 1'b1;
              pbuf[ptr[PW-1:0]]     <= rx_b;
              pvalid[ptr[PW-1:0]]   <= 1'b1;
              ptr[PW-1:0]           <= ptr[PW-1:0] + 1'b1;
              if (wp_i) wp_kill <= 1'b1;
              nxt                   <= S_WD;
            end
            default: ;
          endcase
        end
        if (bitcnt == 4'd8) begin
          bitcnt <= '0;
          if (st == S_RD) begin
            ptr <= ptr + 1'b1;
            if (sda_f) st <= S_IDLE;
          end else st <= nxt;
        end
      end else if (scl_fall && st != S_IDLE) begin
        if (st == S_RD) sda_oe <= (bitcnt < 4'd8) ? ~rd_byte[~bitcnt[2:0]] : 1'b0;
        else            sda_oe <= (bitcnt == 4'd8) && ack_pend;
      end
    end
  end

  assert_drive_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  assert_busy_no_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st == S_DEV) |-> !sda_oe);

  assert_protect_blocks_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!wp_kill && !wp_i));

  assert_protect_aborts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wp_i) |=> !busy);

endmodule

// File: tb/i2c_eeprom_target_bench.sv
module i2c_eeprom_target_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
  logic [2:0] sel = 3'b010;
  logic       sda_oe;
  wire        sda_bus = m_sda & ~sda_oe;

  localparam logic [7:0] DW = 8'hA4, DR = 8'hA5;

  i2c_eeprom_target #(.ADDR_W(8), .DEV_ID(4'hA), .FILT_CYC(3), .WR_CYC(600)) u_i2c_eeprom_target (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sel_i(sel), .wp_i(wp), .sda_oe(sda_oe));

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string      req_q[$];
  logic [7:0] rx_val;
  event       rx_ev;

  task automatic chk_eq(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(logic [7:0] v, string req);
    exp_q.push_back(v);
    req_q.push_back(req);
  endtask

  initial forever begin
    @(rx_ev);
    if (exp_q.size() == 0) chk_eq("R7 unexpected byte", rx_val, 256);
    else chk_eq(req_q.pop_front(), rx_val, exp_q.pop_front());
  end

  task automatic q(); repeat (10) @(negedge clk); endtask
  task automatic i2c_start(); m_sda = 1; q(); m_scl = 1; q(); m_sda = 0; q(); m_scl = 0; q(); endtask
  task automatic i2c_stop();  m_sda = 0; q(); m_scl = 1; q(); m_sda = 1; q(); endtask

  task automatic send_bit(bit b, bit gl);
    m_sda = b; q(); m_scl = 1; q();
    if (gl) begin m_sda = ~b; @(negedge clk); m_sda = b; end
    q(); m_scl = 0; q();
  endtask

  task automatic send_byte(logic [7:0] d, bit gl, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i], gl);
    m_sda = 1; q(); m_scl = 1; q(); ack = ~sda_bus; q(); m_scl = 0; q();
  endtask

  task automatic recv_byte(bit nack);
    logic [7:0] d;
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      q(); m_scl = 1; q(); d[i] = sda_bus; q(); m_scl = 0; q();
    end
    send_bit(nack, 0);
    rx_val = d;
    ->rx_ev;
  endtask

  task automatic write_seq(logic [7:0] a, int n, logic [7:0] d [4], bit gl, string req);
    bit ak; int acks = 0;
    i2c_start();
    send_byte(DW, 0, ak); acks += int'(ak);
    send_byte(a, 0, ak);  acks += int'(ak);
    for (int i = 0; i < n; i++) begin send_byte(d[i], gl, ak); acks += int'(ak); end
    i2c_stop();
    chk_eq({req, " acks"}, acks, n + 2);
  endtask

  task automatic read_seq(bit rnd, logic [7:0] a, int n);
    bit ak;
    if (rnd) begin i2c_start(); send_byte(DW, 0, ak); send_byte(a, 0, ak); end
    i2c_start();
    send_byte(DR, 0, ak);
    chk_eq("R6 read select ack", ak, 1);
    for (int i = 0; i < n; i++) recv_byte(i == n - 1);
    i2c_stop();
  endtask

  task automatic poll(output bit ack);
    i2c_start(); send_byte(DW, 0, ack); i2c_stop();
  endtask

  task automatic settle(); repeat (700) @(negedge clk); endtask

  initial begin
    repeat (1000000) @(posedge clk);
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ak;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk_eq("R3 sda released after reset", sda_oe, 0);

    // R3 erased contents, R6 random read
    push(8'hFF, "R3"); push(8'hFF, "R3"); push(8'hFF, "R3");
    read_seq(1, 8'h00, 3);

    // R2 mismatched strap bits and mismatched id
    i2c_start(); send_byte(8'hA0, 0, ak); i2c_stop();
    chk_eq("R2 strap mismatch nack", ak, 0);
    i2c_start(); send_byte(8'hB4, 0, ak); i2c_stop();
    chk_eq("R2 id mismatch nack", ak, 0);

    // R4 byte write, R8 polling
    write_seq(8'h10, 1, '{8'hA5, 0, 0, 0}, 0, "R4");
    poll(ak); chk_eq("R8 busy nack", ak, 0);
    settle();
    poll(ak); chk_eq("R8 ready ack", ak, 1);
    push(8'hA5, "R4"); read_seq(1, 8'h10, 1);

    // R5 page write, R7 sequential, R6 current address
    write_seq(8'h20, 4, '{8'h11, 8'h22, 8'h33, 8'h44}, 0, "R5"); settle();
    push(8'h11, "R5"); push(8'h22, "R7"); push(8'h33, "R7");
    read_seq(1, 8'h20, 3);
    push(8'h44, "R6 current read"); read_seq(0, 8'h00, 1);

    // R5 wrap inside page 18h..1Fh
    write_seq(8'h1E, 4, '{8'hA1, 8'hA2, 8'hA3, 8'hA4}, 0, "R5"); settle();
    push(8'hA3, "R5 wrap"); push(8'hA4, "R5 wrap"); read_seq(1, 8'h18, 2);
    push(8'hA1, "R5"); push(8'hA2, "R5"); read_seq(1, 8'h1E, 2);

    // R7 full-address wrap
    write_seq(8'hFF, 1, '{8'h5A, 0, 0, 0}, 0, "R7"); settle();
    write_seq(8'h00, 1, '{8'hC3, 0, 0, 0}, 0, "R7"); settle();
    push(8'h5A, "R7"); push(8'hC3, "R7 top wrap"); read_seq(1, 8'hFF, 2);
    chk_eq("R7 released after nack", sda_oe, 0);

    // R9 protect during data phase
    i2c_start(); send_byte(DW, 0, ak); send_byte(8'h10, 0, ak);
    wp = 1; send_byte(8'h00, 0, ak); i2c_stop(); wp = 0;
    poll(ak); chk_eq("R9 no write cycle", ak, 1);
    push(8'hA5, "R9 unchanged"); read_seq(1, 8'h10, 1);

    // R10 protect during write cycle
    write_seq(8'h11, 1, '{8'h77, 0, 0, 0}, 0, "R10");
    repeat (100) @(negedge clk); wp = 1; repeat (10) @(negedge clk); wp = 0;
    poll(ak); chk_eq("R10 cycle ended", ak, 1);
    push(8'hFF, "R10 nothing committed"); read_seq(1, 8'h11, 1);

    // R12 repeated start discards write data
    i2c_start(); send_byte(DW, 0, ak); send_byte(8'h12, 0, ak); send_byte(8'h99, 0, ak);
    push(8'hFF, "R12 current after restart"); read_seq(0, 8'h00, 1);
    poll(ak); chk_eq("R12 no write cycle", ak, 1);
    push(8'hFF, "R12 unchanged"); read_seq(1, 8'h12, 1);

    // R11 short SDA pulses while SCL high
    write_seq(8'h40, 1, '{8'h3C, 0, 0, 0}, 1, "R11"); settle();
    push(8'h3C, "R11 glitch filtered"); read_seq(1, 8'h40, 1);

    repeat (20) @(negedge clk);
    chk_eq("R7 scoreboard drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule